// File: doc/BRIEF.md
# I2C Master Register and Interrupt Front-End

This block is the software-facing part of a FIFO-based I2C master. A simple single-cycle register bus reads and writes word-aligned registers. One address is shared by both FIFOs: a write there pushes a word into the transmit FIFO, and a read there pops a byte from the receive FIFO. The other registers hold the SCL low and high dividers, the own address, the interrupt enables and a buffer-mode bit. Status and the two FIFO fill levels can be read back.

The block collects event pulses from the bit engine. It keeps "transaction done" and "arbitration lost" as sticky flags that software clears by writing a one. The other status bits are live views of the engine and FIFO signals. Each interrupt source is ANDed with its enable bit, and the results are ORed into one level interrupt.

A control bit starts a soft reset. For a fixed number of clocks the FIFOs and the engine are flushed, the sticky flags are cleared and the bit reads back as one. The bit then clears itself. The FIFO storage and the bit engine sit outside this block and connect through plain ports.

Top module: `i2cm_regif`

## Requirements
- R1: After reset, control reads 0, the dividers and own address read 0, both sticky flags are clear and `irq` is low.
- R2: A write to byte offset 0x00 pulses `tx_push` in the same cycle with `tx_data` = wdata[9:0]. No push happens while `tx_full` is high or the soft reset runs. A read of 0x00 returns `rx_data` in bits 7:0 and pulses `rx_pop` only when `rx_empty` is low and no soft reset runs.
- R3: Status at 0x04 reads as follows: bit0 done, bit1 arbitration lost, bit2 `nack_in`, bit3 `drmi_in`, bit5 `bus_active`, bit6 `scl_in`, bit7 `sda_in`, bit8 `rx_full`, bit9 `rx_empty`, bit10 `tx_full`, bit11 `tx_empty`. All other bits read 0.
- R4: The done flag (status bit0) is set by an `ev_done` pulse and the arbitration flag (status bit1) by an `ev_arb_lost` pulse. Writing 1 to the flag's status bit clears it; writing 0 leaves it unchanged.
- R5: When a set pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R6: Control at 0x08 stores interrupt enables in bits 7:0 and the buffer mode in bit10, which drives `buf_mode`. Bit9 and bits above 10 read 0.
- R7: Writing control with bit8 set raises `fifo_flush` from the next cycle for RST_CYCLES cycles (default 4). During that time bit8 reads 1, the enables and buffer mode keep their written values, and both sticky flags are cleared. Afterwards bit8 reads 0.
- R8: The SCL low divider (0x0C) and the SCL high divider (0x10) store wdata[9:0], read back zero-extended and drive `scl_lo_div` and `scl_hi_div`. Upper write bits are dropped.
- R9: The own address at 0x14 stores wdata[6:0] and drives `own_addr`.
- R10: 0x18 reads `rx_level` and 0x1C reads `tx_level`. Writes to these two registers, and to status bits other than bit0 and bit1, have no effect.
- R11: `irq` is the OR, in the same cycle, of each source ANDed with its enable bit. The enable bits map as: bit0 done flag, bit1 arbitration flag, bit2 `nack_in`, bit3 `drmi_in`, bit4 `slv_req_in`, bit5 `rx_full`, bit6 RX not empty, bit7 `tx_full`.
- R12: Reads of byte offsets 0x20 and above return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, same cycle |
| tx_push | output | 1 | Push into transmit FIFO |
| tx_data | output | 10 | Transmit word |
| tx_full | input | 1 | Transmit FIFO full |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_level | input | LVL_W | Transmit fill level |
| rx_pop | output | 1 | Pop from receive FIFO |
| rx_data | input | 8 | Receive FIFO head |
| rx_full | input | 1 | Receive FIFO full |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_level | input | LVL_W | Receive fill level |
| fifo_flush | output | 1 | Soft reset of FIFOs and engine |
| ev_done | input | 1 | Transaction-done pulse |
| ev_arb_lost | input | 1 | Arbitration-lost pulse |
| nack_in | input | 1 | No-acknowledge seen |
| drmi_in | input | 1 | Engine needs transmit data |
| slv_req_in | input | 1 | Slave data request |
| bus_active | input | 1 | Bus busy |
| scl_in | input | 1 | Live SCL level |
| sda_in | input | 1 | Live SDA level |
| scl_lo_div | output | 10 | SCL low divider |
| scl_hi_div | output | 10 | SCL high divider |
| own_addr | output | 7 | Own address |
| buf_mode | output | 1 | Alternate buffer mode |
| irq | output | 1 | Level interrupt |

## Verification
A done pulse from the engine can arrive in the same cycle as a software write that clears that flag. The bench drives `ev_done` high in exactly the cycle of a one-write to status bit0. It then reads status and expects bit0 still set, so the new event survives the clear. A second overlap is an event, or a transmit write, that lands inside the soft-reset window. There the flush must win: the flag ends clear and no push leaves the block.

// File: rtl/i2cm_regif_pkg.sv
package i2cm_regif_pkg;
    localparam int DIV_W   = 10;
    localparam int OWN_W   = 7;
    localparam int TXW_W   = 10;
    localparam int RXW_W   = 8;
    localparam int NUM_SRC = 8;
    localparam int NUM_FLG = 2;

    // word indices of the register map
    localparam int IDX_DATA = 0;
    localparam int IDX_STAT = 1;
    localparam int IDX_CTRL = 2;
    localparam int IDX_DLO  = 3;
    localparam int IDX_DHI  = 4;
    localparam int IDX_OWN  = 5;
    localparam int IDX_RXL  = 6;
    localparam int IDX_TXL  = 7;

    localparam int CTRL_RST_BIT  = 8;
    localparam int CTRL_BUFM_BIT = 10;

    typedef struct packed {
        logic [NUM_SRC-1:0] ien;
        logic               bufm;
        logic [DIV_W-1:0]   dlo;
        logic [DIV_W-1:0]   dhi;
        logic [OWN_W-1:0]   own;
    } cfg_t;
endpackage

// File: rtl/i2cm_sticky_flags.sv
module i2cm_sticky_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag
);
    logic [N-1:0] flag_d, flag_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // set beats clear; flush beats both
        always_comb begin
            if (flush)
                flag_d[i] = 1'b0;
            else
                flag_d[i] = set[i] | (flag_q[i] & ~clr[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
endmodule

// File: rtl/i2cm_rst_seq.sv
module i2cm_rst_seq #(
    parameter int CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(CYC + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = CNT_W'(CYC);
        else if (cnt_q != '0)
            cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/i2cm_irq_merge.sv
module i2cm_irq_merge #(
    parameter int N = 8
) (
    input  logic [N-1:0] src,
    input  logic [N-1:0] en,
    output logic         irq
);
    logic [N-1:0] hit;

    for (genvar i = 0; i < N; i++) begin : g_src
        assign hit[i] = src[i] & en[i];
    end

    assign irq = |hit;
endmodule

// File: rtl/i2cm_regif.sv
module i2cm_regif
    import i2cm_regif_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 32,
    parameter int LVL_W      = 4,
    parameter int RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tx_push,
    output logic [TXW_W-1:0]  tx_data,
    input  logic              tx_full,
    input  logic              tx_empty,
    input  logic [LVL_W-1:0]  tx_level,
    output logic              rx_pop,
    input  logic [RXW_W-1:0]  rx_data,
    input  logic              rx_full,
    input  logic              rx_empty,
    input  logic [LVL_W-1:0]  rx_level,
    output logic              fifo_flush,
    input  logic              ev_done,
    input  logic              ev_arb_lost,
    input  logic              nack_in,
    input  logic              drmi_in,
    input  logic              slv_req_in,
    input  logic              bus_active,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic [DIV_W-1:0]  scl_lo_div,
    output logic [DIV_W-1:0]  scl_hi_div,
    output logic [OWN_W-1:0]  own_addr,
    output logic              buf_mode,
    output logic              irq
);
    localparam int WIDX_W = ADDR_W - 2;
    localparam int STAT_W = 12;
    localparam int CTRL_W = CTRL_BUFM_BIT + 1;

    localparam logic [WIDX_W-1:0] W_DATA = WIDX_W'(IDX_DATA);
    localparam logic [WIDX_W-1:0] W_STAT = WIDX_W'(IDX_STAT);
    localparam logic [WIDX_W-1:0] W_CTRL = WIDX_W'(IDX_CTRL);
    localparam logic [WIDX_W-1:0] W_DLO  = WIDX_W'(IDX_DLO);
    localparam logic [WIDX_W-1:0] W_DHI  = WIDX_W'(IDX_DHI);
    localparam logic [WIDX_W-1:0] W_OWN  = WIDX_W'(IDX_OWN);
    localparam logic [WIDX_W-1:0] W_RXL  = WIDX_W'(IDX_RXL);
    localparam logic [WIDX_W-1:0] W_TXL  = WIDX_W'(IDX_TXL);

    logic [WIDX_W-1:0]  widx;
    logic               wr_en, rd_en;
    cfg_t               cfg_d, cfg_q;
    logic               rst_start, rst_busy;
    logic [NUM_FLG-1:0] flag_set, flag_clr, flags_q;
    logic [STAT_W-1:0]  stat_word;
    logic [CTRL_W-1:0]  ctrl_word;
    logic [NUM_SRC-1:0] irq_src;
    logic               unused_bits;

    assign widx  = bus_addr[ADDR_W-1:2];
    assign wr_en = bus_sel & bus_we;
    assign rd_en = bus_sel & ~bus_we;
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:CTRL_W]};

    // configuration registers: next-state logic
    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (widx)
                W_CTRL: begin
                    cfg_d.ien  = bus_wdata[NUM_SRC-1:0];
                    cfg_d.bufm = bus_wdata[CTRL_BUFM_BIT];
                end
                W_DLO:   cfg_d.dlo = bus_wdata[DIV_W-1:0];
                W_DHI:   cfg_d.dhi = bus_wdata[DIV_W-1:0];
                W_OWN:   cfg_d.own = bus_wdata[OWN_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    // soft reset sequencer
    assign rst_start = wr_en && (widx == W_CTRL) && bus_wdata[CTRL_RST_BIT];

    i2cm_rst_seq #(.CYC(RST_CYCLES)) u_rst (
        .clk   (clk),
        .rst_n (rst_n),
        .start (rst_start),
        .busy  (rst_busy)
    );

    // sticky event flags, bit0 done, bit1 arbitration lost
    assign flag_set = {ev_arb_lost, ev_done};
    assign flag_clr = (wr_en && (widx == W_STAT)) ? bus_wdata[NUM_FLG-1:0] : '0;

    i2cm_sticky_flags #(.N(NUM_FLG)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rst_busy),
        .set   (flag_set),
        .clr   (flag_clr),
        .flag  (flags_q)
    );

    // interrupt merge
    assign irq_src = {tx_full, ~rx_empty, rx_full, slv_req_in,
                      drmi_in, nack_in, flags_q[1], flags_q[0]};

    i2cm_irq_merge #(.N(NUM_SRC)) u_irq (
        .src (irq_src),
        .en  (cfg_q.ien),
        .irq (irq)
    );

    // read path
    assign stat_word = {tx_empty, tx_full, rx_empty, rx_full,
                        sda_in, scl_in, bus_active, 1'b0,
                        drmi_in, nack_in, flags_q[1], flags_q[0]};
    assign ctrl_word = {cfg_q.bufm, 1'b0, rst_busy, cfg_q.ien};

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (widx)
                W_DATA:  bus_rdata = DATA_W'(rx_data);
                W_STAT:  bus_rdata = DATA_W'(stat_word);
                W_CTRL:  bus_rdata = DATA_W'(ctrl_word);
                W_DLO:   bus_rdata = DATA_W'(cfg_q.dlo);
                W_DHI:   bus_rdata = DATA_W'(cfg_q.dhi);
                W_OWN:   bus_rdata = DATA_W'(cfg_q.own);
                W_RXL:   bus_rdata = DATA_W'(rx_level);
                W_TXL:   bus_rdata = DATA_W'(tx_level);
                default: bus_rdata = '0;
            endcase
        end
    end

    // FIFO strobes
    assign tx_push = wr_en && (widx == W_DATA) && !tx_full  && !rst_busy;
    assign rx_pop  = rd_en && (widx == W_DATA) && !rx_empty && !rst_busy;
    assign tx_data = bus_wdata[TXW_W-1:0];

    assign fifo_flush = rst_busy;
    assign scl_lo_div = cfg_q.dlo;
    assign scl_hi_div = cfg_q.dhi;
    assign own_addr   = cfg_q.own;
    assign buf_mode   = cfg_q.bufm;
endmodule

// File: rtl/i2cm_regif_chk.sv
module i2cm_regif_chk #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              tx_push,
    input logic              tx_full,
    input logic              rx_pop,
    input logic              rx_empty,
    input logic              fifo_flush,
    input logic              ev_done,
    input logic              done_flag,
    input logic [9:0]        scl_lo_div
);
    localparam logic [ADDR_W-3:0] C_CTRL = (ADDR_W-2)'(2);
    localparam logic [ADDR_W-3:0] C_DLO  = (ADDR_W-2)'(3);

    // R2
    push_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> (!tx_full && !fifo_flush));

    // R2
    pop_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> (!rx_empty && !fifo_flush));

    // R7
    rst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr[ADDR_W-1:2] == C_CTRL && bus_wdata[8]) |=> fifo_flush);

    // R7
    rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fifo_flush) |=> fifo_flush);

    // R7
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |=> !done_flag);

    // R5
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_done && !fifo_flush) |=> done_flag);

    // R8
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_we && bus_addr[ADDR_W-1:2] == C_DLO) |=> $stable(scl_lo_div));
endmodule

bind i2cm_regif i2cm_regif_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .tx_push    (tx_push),
    .tx_full    (tx_full),
    .rx_pop     (rx_pop),
    .rx_empty   (rx_empty),
    .fifo_flush (fifo_flush),
    .ev_done    (ev_done),
    .done_flag  (flags_q[0]),
    .scl_lo_div (scl_lo_div)
);

// File: tb/i2cm_regif_test.sv
`timescale 1ns/1ps
module i2cm_regif_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_push, rx_pop, fifo_flush, buf_mode, irq;
    logic [9:0]  tx_data, scl_lo_div, scl_hi_div;
    logic [6:0]  own_addr;
    logic        tx_full = 0, tx_empty = 1, rx_full = 0, rx_empty = 1;
    logic [3:0]  tx_level = '0, rx_level = '0;
    logic [7:0]  rx_data = '0;
    logic        ev_done = 0, ev_arb_lost = 0, nack_in = 0, drmi_in = 0;
    logic        slv_req_in = 0, bus_active = 0, scl_in = 1, sda_in = 1;

    int n_chk = 0;
    int n_err = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_t;
    sb_t sb_q[$];
    sb_t it;

    always #2 clk = ~clk;

    i2cm_regif uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full),
        .tx_empty(tx_empty), .tx_level(tx_level), .rx_pop(rx_pop),
        .rx_data(rx_data), .rx_full(rx_full), .rx_empty(rx_empty),
        .rx_level(rx_level), .fifo_flush(fifo_flush), .ev_done(ev_done),
        .ev_arb_lost(ev_arb_lost), .nack_in(nack_in), .drmi_in(drmi_in),
        .slv_req_in(slv_req_in), .bus_active(bus_active), .scl_in(scl_in),
        .sda_in(sda_in), .scl_lo_div(scl_lo_div), .scl_hi_div(scl_hi_div),
        .own_addr(own_addr), .buf_mode(buf_mode), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected status word built from the bit layout of R3
    function automatic logic [31:0] stat_exp(input logic d, input logic a);
        return {20'b0, tx_empty, tx_full, rx_empty, rx_full, sda_in, scl_in,
                bus_active, 1'b0, drmi_in, nack_in, a, d};
    endfunction

    // monitor: pops expected read data and compares
    always begin
        @(negedge clk);
        #1;
        if (sb_q.size() > 0 && bus_sel && !bus_we) begin
            it = sb_q.pop_front();
            chk(it.tag, bus_rdata, it.exp);
        end
    end

    task automatic bus_idle();
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        #1;
    endtask

    task automatic bus_rd(input logic [5:0] a, input logic [31:0] e, input string tag);
        sb_t s;
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        s.exp = e; s.tag = tag;
        sb_q.push_back(s);
        #1;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        bus_sel = 0; ev_done = 1;
        @(negedge clk);
        ev_done = 0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        bus_rd(6'h08, 32'h0, "R1 ctrl");
        bus_rd(6'h0C, 32'h0, "R1 div");
        bus_rd(6'h04, stat_exp(0, 0), "R1/R3 status");
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R8 dividers
        bus_wr(6'h0C, 32'hFFFF_F5A5);
        bus_wr(6'h10, 32'h0000_07FF);
        bus_rd(6'h0C, 32'h1A5, "R8 lo");
        chk("R8 lo port", {22'b0, scl_lo_div}, 32'h1A5);
        bus_rd(6'h10, 32'h3FF, "R8 hi");
        chk("R8 hi port", {22'b0, scl_hi_div}, 32'h3FF);

        // R9 own address
        bus_wr(6'h14, 32'h0000_00FF);
        bus_rd(6'h14, 32'h7F, "R9");
        chk("R9 port", {25'b0, own_addr}, 32'h7F);

        // R6 control, bit9 written but reads zero
        bus_wr(6'h08, 32'hFFFF_F6FF & 32'h0000_06FF);
        bus_rd(6'h08, 32'h4FF, "R6 ctrl");
        chk("R6 buf_mode", {31'b0, buf_mode}, 32'h1);
        chk("R11 all enabled no source", {31'b0, irq}, 32'h0);
        bus_wr(6'h08, 32'h0);

        // R4 done flag
        pulse_done();
        bus_rd(6'h04, stat_exp(1, 0), "R4 done set");
        bus_wr(6'h04, 32'h0);
        bus_rd(6'h04, stat_exp(1, 0), "R4 write zero keeps");
        bus_wr(6'h04, 32'h1);
        bus_rd(6'h04, stat_exp(0, 0), "R4 done cleared");

        // R4 arbitration flag
        @(negedge clk); bus_sel = 0; ev_arb_lost = 1;
        @(negedge clk); ev_arb_lost = 0;
        bus_rd(6'h04, stat_exp(0, 1), "R4 arb set");
        bus_wr(6'h04, 32'h2);
        bus_rd(6'h04, stat_exp(0, 0), "R4 arb cleared");

        // R5 set and clear in the same cycle
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = 6'h04; bus_wdata = 32'h1; ev_done = 1;
        @(negedge clk); ev_done = 0; bus_sel = 0;
        bus_rd(6'h04, stat_exp(1, 0), "R5 event wins");

        // R11 interrupt sources
        bus_wr(6'h08, 32'h1);
        bus_idle(); #1;
        chk("R11 done enabled", {31'b0, irq}, 32'h1);
        bus_wr(6'h08, 32'h0);
        bus_idle(); #1;
        chk("R11 done masked", {31'b0, irq}, 32'h0);
        bus_wr(6'h04, 32'h1);
        bus_wr(6'h08, 32'h4);
        bus_idle(); nack_in = 1; #1;
        chk("R11 nack", {31'b0, irq}, 32'h1);
        nack_in = 0; #1;
        chk("R11 nack low", {31'b0, irq}, 32'h0);
        bus_wr(6'h08, 32'h40);
        bus_idle(); rx_empty = 0; #1;
        chk("R11 rx not empty", {31'b0, irq}, 32'h1);
        rx_empty = 1; #1;
        chk("R11 rx empty", {31'b0, irq}, 32'h0);
        bus_wr(6'h08, 32'h10);
        bus_idle(); slv_req_in = 1; #1;
        chk("R11 slave req", {31'b0, irq}, 32'h1);
        slv_req_in = 0;
        bus_wr(6'h08, 32'h0);

        // R3 alternate live pattern
        bus_idle();
        bus_active = 1; drmi_in = 1; rx_full = 1; tx_full = 1;
        tx_empty = 0; scl_in = 0; sda_in = 0; rx_empty = 0;
        bus_rd(6'h04, stat_exp(0, 0), "R3 live bits");

        // R2 data path
        bus_wr(6'h00, 32'h0000_03AB);
        chk("R2 push blocked full", {31'b0, tx_push}, 32'h0);
        tx_full = 0;
        bus_wr(6'h00, 32'h0000_03AB);
        chk("R2 push", {31'b0, tx_push}, 32'h1);
        chk("R2 tx_data", {22'b0, tx_data}, 32'h3AB);
        rx_data = 8'h5C;
        bus_rd(6'h00, 32'h5C, "R2 rx data");
        chk("R2 pop", {31'b0, rx_pop}, 32'h1);
        bus_idle();
        rx_empty = 1;
        bus_rd(6'h00, 32'h5C, "R2 rx read empty");
        chk("R2 no pop when empty", {31'b0, rx_pop}, 32'h0);

        // R10 levels and read-only writes
        bus_active = 0; drmi_in = 0; rx_full = 0; tx_empty = 1;
        scl_in = 1; sda_in = 1;
        rx_level = 4'd3; tx_level = 4'd2;
        bus_wr(6'h18, 32'hFFFF_FFFF);
        bus_rd(6'h18, 32'h3, "R10 rx level");
        bus_wr(6'h1C, 32'h0000_000F);
        bus_rd(6'h1C, 32'h2, "R10 tx level");
        bus_wr(6'h04, 32'hFFFF_FFFC);
        bus_rd(6'h04, stat_exp(0, 0), "R10 status ro");

        // R12 unmapped
        bus_rd(6'h20, 32'h0, "R12 0x20");
        bus_rd(6'h3C, 32'h0, "R12 0x3C");

        // R7 soft reset
        pulse_done();
        bus_wr(6'h08, 32'h0000_0101);
        chk("R7 flush not yet", {31'b0, fifo_flush}, 32'h0);
        bus_rd(6'h08, 32'h101, "R7 bit reads one");
        chk("R7 flush c1", {31'b0, fifo_flush}, 32'h1);
        bus_wr(6'h00, 32'h0000_0055);
        chk("R7 no push in flush", {31'b0, tx_push}, 32'h0);
        chk("R7 flush c2", {31'b0, fifo_flush}, 32'h1);
        bus_idle(); ev_done = 1; #1;
        chk("R7 flush c3", {31'b0, fifo_flush}, 32'h1);
        bus_idle(); ev_done = 0; #1;
        chk("R7 flush c4", {31'b0, fifo_flush}, 32'h1);
        bus_idle(); #1;
        chk("R7 flush over", {31'b0, fifo_flush}, 32'h0);
        bus_rd(6'h08, 32'h001, "R7 bit self-cleared");
        bus_rd(6'h04, stat_exp(0, 0), "R7 flags cleared");
        bus_idle();

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule